// File: doc/BRIEF.md
# Colour LCD Controller Register Bank

This block is the bus-facing register file of a simple colour LCD controller. It sits on a 4 KB slave window and takes single-cycle, word-aligned 32-bit accesses. It holds the following state:

- four panel-timing words;
- the upper and lower frame base addresses;
- a control word and an interrupt mask;
- a raw interrupt status vector, cleared by writing ones;
- a 128-word colour palette.

A read-only window at the top of the space returns eight identification bytes.

The bank decodes panel geometry and display mode for the downstream scan-out and pixel logic. It derives the pixels per line, the lines per panel, the colour depth, the three ordering selects and a combined display-enable. A parameter picks one of two register-map variants. The newer variant exchanges the offsets of the control word and the interrupt mask, and it returns different identification bytes.

Read data and the error flag are registered. A read presented before clock edge k shows its result after edge k. Interrupt events arrive as single-cycle pulses on a side input and set bits of the raw status.

Top module: `lcd_regbank`

## Requirements
- R1: Word indices 0-3 (offsets 0x000-0x00C) hold four 32-bit timing words, and indices 4 and 5 (0x010, 0x014) hold the upper and lower base addresses. Each reads back exactly what was written, and the base addresses drive `upperBase` and `lowerBase`.
- R2: With `VARIANT`=0, index 6 (0x018) is the control word and index 7 (0x01C) is the interrupt mask. With `VARIANT`=1 the two are exchanged. The mask keeps only its low 4 bits and reads back zero-extended.
- R3: Index 8 (0x020) reads the 4-bit raw interrupt status, and index 9 (0x024) reads raw status AND mask.
- R4: A write to index 10 (0x028) clears each raw status bit whose write-data bit is 1. An event pulse on `intEvt` sets the matching bit, and a set in the same cycle as a clear wins.
- R5: Offsets 0x200-0x3FC address a 128-word palette that reads back written data.
- R6: Offsets 0xFE0-0xFFC return one identification byte per word, zero-extended. `VARIANT`=0 gives 0x10,0x11,0x04,0x00,0x0D,0xF0,0x05,0xB1 and `VARIANT`=1 gives 0x11,0x11,0x24,0x00,0x0D,0xF0,0x05,0xB1, lowest offset first.
- R7: `pixPerLine` equals ((timing0 & 0xFC) + 4) * 4, so it ranges from 16 to 1024.
- R8: `lineCount` equals (timing1 & 0x3FF) + 1.
- R9: `dispEnable` is 1 only when control bits 0 and 11 are both 1. `colourDepth` is control bits 3:1, `bgrOrder` is bit 8, `bigEndByte` is bit 9 and `bigEndPix` is bit 10.
- R10: Indices 11 and 12 (0x02C, 0x030) read zero without error. Writes to read-only locations (indices 8, 9, 11, 12 and the identification window) change nothing.
- R11: A read of an undefined offset returns zero and raises `busErr` for that result. This covers offsets 0x034-0x1FC, index 10, 0x400-0xFDC and any offset with nonzero low two bits. Writes to these offsets change nothing.
- R12: `intOut` is 1 exactly when raw status AND mask is nonzero.
- R13: Reset clears every register, the palette, the read data and the error flag. After reset, `pixPerLine` is 16 and `lineCount` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busSel | input | 1 | Access request this cycle |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | 12 | Byte offset within the window |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Registered read data |
| busErr | output | 1 | Registered flag: last read hit an undefined offset |
| intEvt | input | 4 | Interrupt event pulses, one per status bit |
| intOut | output | 1 | Interrupt request |
| pixPerLine | output | 12 | Decoded pixels per line |
| lineCount | output | 11 | Decoded lines per panel |
| colourDepth | output | 3 | Colour depth select |
| bgrOrder | output | 1 | Blue/red swap select |
| bigEndByte | output | 1 | Big-endian byte order select |
| bigEndPix | output | 1 | Big-endian pixel order within a byte |
| dispEnable | output | 1 | Enable and power both set |
| upperBase | output | 32 | Upper panel base address |
| lowerBase | output | 32 | Lower panel base address |

## Verification
The hardest case to reach from the ports is the race between an event pulse and a clear write that target the same status bit in the same cycle. The stimulus aligns an `intEvt` pulse with a write to index 10 on one edge and then reads raw status. The variant swap is also hard to see on one instance. So the bench drives a second instance with the other `VARIANT` from the same bus after a fresh reset. It then compares the two readbacks of indices 6 and 7, their `dispEnable` outputs and their identification bytes.

// File: rtl/lcdreg_pkg.sv
package lcdreg_pkg;
  localparam int ADDR_W    = 12;
  localparam int DATA_W    = 32;
  localparam int INT_W     = 4;
  localparam int PAL_WORDS = 128;
  localparam int PAL_AW    = $clog2(PAL_WORDS);
  localparam int TIM_NUM   = 4;
  localparam int TIM_AW    = $clog2(TIM_NUM);
  localparam int IDX_W     = ADDR_W - 2;
  localparam int ID_WORDS  = 8;

  typedef enum logic [3:0] {
    RD_TIM, RD_UPB, RD_LPB, RD_CTRL, RD_MASK, RD_RAW,
    RD_MSKD, RD_PAL, RD_ID, RD_ZERO, RD_BAD
  } rdsel_e;

  typedef struct packed {
    logic              wrTim;
    logic [TIM_AW-1:0] timIdx;
    logic              wrUpb;
    logic              wrLpb;
    logic              wrCtrl;
    logic              wrMask;
    logic              wrClr;
    logic              wrPal;
    logic              rdEn;
    rdsel_e            rdSel;
    logic [PAL_AW-1:0] idx;
  } strobe_t;

  function automatic logic [7:0] idByte(input int variant, input logic [2:0] k);
    logic [7:0] b;
    case (k)
      3'd0: b = (variant == 0) ? 8'h10 : 8'h11;
      3'd1: b = 8'h11;
      3'd2: b = (variant == 0) ? 8'h04 : 8'h24;
      3'd3: b = 8'h00;
      3'd4: b = 8'h0D;
      3'd5: b = 8'hF0;
      3'd6: b = 8'h05;
      default: b = 8'hB1;
    endcase
    return b;
  endfunction
endpackage

// File: rtl/lcdreg_ctrl.sv
module lcdreg_ctrl
  import lcdreg_pkg::*;
#(
  parameter int VARIANT = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  output strobe_t           strb
);
  localparam int CTRL_IDX = (VARIANT == 0) ? 6 : 7;
  localparam int MASK_IDX = (VARIANT == 0) ? 7 : 6;
  localparam logic [IDX_W-1:0] PAL_LO  = IDX_W'(PAL_WORDS);
  localparam logic [IDX_W-1:0] PAL_HI  = IDX_W'(2 * PAL_WORDS);
  localparam logic [IDX_W-1:0] ID_LO   = IDX_W'((1 << IDX_W) - ID_WORDS);
  localparam logic [IDX_W-1:0] I_UPB   = IDX_W'(4);
  localparam logic [IDX_W-1:0] I_LPB   = IDX_W'(5);
  localparam logic [IDX_W-1:0] I_CTRL  = IDX_W'(CTRL_IDX);
  localparam logic [IDX_W-1:0] I_MASK  = IDX_W'(MASK_IDX);
  localparam logic [IDX_W-1:0] I_RAW   = IDX_W'(8);
  localparam logic [IDX_W-1:0] I_MSKD  = IDX_W'(9);
  localparam logic [IDX_W-1:0] I_CLR   = IDX_W'(10);
  localparam logic [IDX_W-1:0] I_CURA  = IDX_W'(11);
  localparam logic [IDX_W-1:0] I_CURB  = IDX_W'(12);
  localparam logic [IDX_W-1:0] I_TIMHI = IDX_W'(TIM_NUM);

  logic [IDX_W-1:0] wordIdx;
  logic             aligned;
  logic             doWr;

  assign wordIdx = busAddr[ADDR_W-1:2];
  assign aligned = (busAddr[1:0] == 2'b00);
  assign doWr    = busSel && busWr && aligned;

  always_comb begin
    strb        = '0;
    strb.rdSel  = RD_BAD;
    strb.idx    = wordIdx[PAL_AW-1:0];
    strb.timIdx = wordIdx[TIM_AW-1:0];
    strb.rdEn   = busSel && !busWr;
    if (!aligned) begin
      strb.rdSel = RD_BAD;
    end else if (wordIdx >= PAL_LO && wordIdx < PAL_HI) begin
      strb.rdSel = RD_PAL;
      strb.wrPal = doWr;
    end else if (wordIdx >= ID_LO) begin
      strb.rdSel = RD_ID;
    end else if (wordIdx < I_TIMHI) begin
      strb.rdSel = RD_TIM;
      strb.wrTim = doWr;
    end else if (wordIdx == I_UPB) begin
      strb.rdSel = RD_UPB;
      strb.wrUpb = doWr;
    end else if (wordIdx == I_LPB) begin
      strb.rdSel = RD_LPB;
      strb.wrLpb = doWr;
    end else if (wordIdx == I_CTRL) begin
      strb.rdSel  = RD_CTRL;
      strb.wrCtrl = doWr;
    end else if (wordIdx == I_MASK) begin
      strb.rdSel  = RD_MASK;
      strb.wrMask = doWr;
    end else if (wordIdx == I_RAW) begin
      strb.rdSel = RD_RAW;
    end else if (wordIdx == I_MSKD) begin
      strb.rdSel = RD_MSKD;
    end else if (wordIdx == I_CLR) begin
      strb.rdSel = RD_BAD;
      strb.wrClr = doWr;
    end else if (wordIdx == I_CURA || wordIdx == I_CURB) begin
      strb.rdSel = RD_ZERO;
    end
  end

  // At most one register write strobe per access (R1)
  p_one_write_r1: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.wrTim, strb.wrUpb, strb.wrLpb, strb.wrCtrl,
              strb.wrMask, strb.wrClr, strb.wrPal}));

  // A misaligned access never produces a write strobe (R11)
  p_misaligned_nowr_r11: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && busAddr[1:0] != 2'b00) |->
      !(strb.wrTim || strb.wrUpb || strb.wrLpb || strb.wrCtrl ||
        strb.wrMask || strb.wrClr || strb.wrPal));
endmodule

// File: rtl/lcdreg_dpath.sv
module lcdreg_dpath
  import lcdreg_pkg::*;
#(
  parameter int VARIANT = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [DATA_W-1:0] busWdata,
  input  logic [INT_W-1:0]  intEvt,
  output logic [DATA_W-1:0] busRdata,
  output logic              busErr,
  output logic              intOut,
  output logic [11:0]       pixPerLine,
  output logic [10:0]       lineCount,
  output logic [2:0]        colourDepth,
  output logic              bgrOrder,
  output logic              bigEndByte,
  output logic              bigEndPix,
  output logic              dispEnable,
  output logic [DATA_W-1:0] upperBase,
  output logic [DATA_W-1:0] lowerBase
);
  logic [DATA_W-1:0] timReg [TIM_NUM];
  logic [DATA_W-1:0] ctrlReg;
  logic [INT_W-1:0]  intMask;
  logic [INT_W-1:0]  intRaw;
  logic [INT_W-1:0]  clrBits;
  logic [DATA_W-1:0] palMem [PAL_WORDS];
  logic [DATA_W-1:0] rdMux;

  assign clrBits = strb.wrClr ? busWdata[INT_W-1:0] : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < TIM_NUM; i++) timReg[i] <= '0;
      upperBase <= '0;
      lowerBase <= '0;
      ctrlReg   <= '0;
      intMask   <= '0;
      intRaw    <= '0;
    end else begin
      if (strb.wrTim)  timReg[strb.timIdx] <= busWdata;
      if (strb.wrUpb)  upperBase <= busWdata;
      if (strb.wrLpb)  lowerBase <= busWdata;
      if (strb.wrCtrl) ctrlReg   <= busWdata;
      if (strb.wrMask) intMask   <= busWdata[INT_W-1:0];
      intRaw <= (intRaw & ~clrBits) | intEvt;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < PAL_WORDS; i++) palMem[i] <= '0;
    end else if (strb.wrPal) begin
      palMem[strb.idx] <= busWdata;
    end
  end

  always_comb begin
    rdMux = '0;
    case (strb.rdSel)
      RD_TIM:  rdMux = timReg[strb.timIdx];
      RD_UPB:  rdMux = upperBase;
      RD_LPB:  rdMux = lowerBase;
      RD_CTRL: rdMux = ctrlReg;
      RD_MASK: rdMux = DATA_W'(intMask);
      RD_RAW:  rdMux = DATA_W'(intRaw);
      RD_MSKD: rdMux = DATA_W'(intRaw & intMask);
      RD_PAL:  rdMux = palMem[strb.idx];
      RD_ID:   rdMux = DATA_W'(idByte(VARIANT, strb.idx[2:0]));
      default: rdMux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busRdata <= '0;
      busErr   <= 1'b0;
    end else begin
      busErr <= 1'b0;
      if (strb.rdEn) begin
        busRdata <= rdMux;
        busErr   <= (strb.rdSel == RD_BAD);
      end
    end
  end

  assign pixPerLine  = {1'b0, ({5'b0, timReg[0][7:2]} + 11'd1) << 4};
  assign lineCount   = {1'b0, timReg[1][9:0]} + 11'd1;
  assign colourDepth = ctrlReg[3:1];
  assign bgrOrder    = ctrlReg[8];
  assign bigEndByte  = ctrlReg[9];
  assign bigEndPix   = ctrlReg[10];
  assign dispEnable  = ctrlReg[0] & ctrlReg[11];
  assign intOut      = |(intRaw & intMask);

  // Clear write with no concurrent event leaves the cleared bits at zero (R4)
  p_w1c_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrClr && intEvt == '0) |=> ((intRaw & $past(busWdata[INT_W-1:0])) == '0));

  // Interrupt output needs a nonzero mask (R12)
  p_irq_mask_r12: assert property (@(posedge clk) disable iff (!rstN)
    intOut |-> (intMask != '0));

  // Error reads return zero data (R11)
  p_err_zero_r11: assert property (@(posedge clk) disable iff (!rstN)
    busErr |-> (busRdata == '0));

  // Geometry only moves after a timing write (R7)
  p_geom_r7: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(pixPerLine) |-> $past(strb.wrTim));

  // Display enable only rises after a control write (R9)
  p_enable_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dispEnable) |-> $past(strb.wrCtrl));
endmodule

// File: rtl/lcd_regbank.sv
module lcd_regbank
  import lcdreg_pkg::*;
#(
  parameter int VARIANT = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              busErr,
  input  logic [INT_W-1:0]  intEvt,
  output logic              intOut,
  output logic [11:0]       pixPerLine,
  output logic [10:0]       lineCount,
  output logic [2:0]        colourDepth,
  output logic              bgrOrder,
  output logic              bigEndByte,
  output logic              bigEndPix,
  output logic              dispEnable,
  output logic [DATA_W-1:0] upperBase,
  output logic [DATA_W-1:0] lowerBase
);
  strobe_t strb;

  lcdreg_ctrl #(.VARIANT(VARIANT)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .busSel  (busSel),
    .busWr   (busWr),
    .busAddr (busAddr),
    .strb    (strb)
  );

  lcdreg_dpath #(.VARIANT(VARIANT)) u_dpath (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .busWdata    (busWdata),
    .intEvt      (intEvt),
    .busRdata    (busRdata),
    .busErr      (busErr),
    .intOut      (intOut),
    .pixPerLine  (pixPerLine),
    .lineCount   (lineCount),
    .colourDepth (colourDepth),
    .bgrOrder    (bgrOrder),
    .bigEndByte  (bigEndByte),
    .bigEndPix   (bigEndPix),
    .dispEnable  (dispEnable),
    .upperBase   (upperBase),
    .lowerBase   (lowerBase)
  );
endmodule

// File: tb/lcd_regbank_test.sv
`timescale 1ns/1ps
module lcd_regbank_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busSel = 1'b0;
  logic        busWr = 1'b0;
  logic [11:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [3:0]  intEvt = '0;

  logic [31:0] busRdata, upperBase, lowerBase;
  logic        busErr, intOut, bgrOrder, bigEndByte, bigEndPix, dispEnable;
  logic [11:0] pixPerLine;
  logic [10:0] lineCount;
  logic [2:0]  colourDepth;

  logic [31:0] aRdata, aUpper, aLower;
  logic        aErr, aInt, aBgr, aBeB, aBeP, aEn;
  logic [11:0] aPpl;
  logic [10:0] aLines;
  logic [2:0]  aDepth;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  lcd_regbank #(.VARIANT(0)) uut (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .busErr(busErr), .intEvt(intEvt),
    .intOut(intOut), .pixPerLine(pixPerLine), .lineCount(lineCount),
    .colourDepth(colourDepth), .bgrOrder(bgrOrder), .bigEndByte(bigEndByte),
    .bigEndPix(bigEndPix), .dispEnable(dispEnable), .upperBase(upperBase),
    .lowerBase(lowerBase));

  lcd_regbank #(.VARIANT(1)) uutAlt (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(aRdata), .busErr(aErr), .intEvt(intEvt),
    .intOut(aInt), .pixPerLine(aPpl), .lineCount(aLines),
    .colourDepth(aDepth), .bgrOrder(aBgr), .bigEndByte(aBeB),
    .bigEndPix(aBeP), .dispEnable(aEn), .upperBase(aUpper),
    .lowerBase(aLower));

  typedef struct {
    bit          alt;
    logic [31:0] data;
    logic        err;
    string       tag;
  } exp_t;

  exp_t expQ[$];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  // Monitor: compare registered read results against the scoreboard
  always @(negedge clk) begin
    while (expQ.size() > 0) begin
      exp_t e;
      e = expQ.pop_front();
      chk({e.tag, " data"}, e.alt ? aRdata : busRdata, e.data);
      chk({e.tag, " err"}, {31'b0, e.alt ? aErr : busErr}, {31'b0, e.err});
    end
  end

  task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic [3:0] ev = 4'h0);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b1; busAddr = a; busWdata = d; intEvt = ev;
    @(negedge clk);
    busSel = 1'b0; busWr = 1'b0; intEvt = 4'h0;
  endtask

  task automatic rdBoth(input logic [11:0] a, input logic [31:0] d, input logic e,
                        input bit withAlt, input logic [31:0] ad, input logic ae,
                        input string tag);
    exp_t x;
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b0; busAddr = a;
    @(posedge clk);
    #1;
    x.alt = 1'b0; x.data = d; x.err = e; x.tag = tag;
    expQ.push_back(x);
    if (withAlt) begin
      x.alt = 1'b1; x.data = ad; x.err = ae; x.tag = {tag, " alt"};
      expQ.push_back(x);
    end
    @(negedge clk);
    busSel = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] d, input logic e, input string tag);
    rdBoth(a, d, e, 1'b0, 32'h0, 1'b0, tag);
  endtask

  task automatic pulse(input logic [3:0] ev);
    @(negedge clk);
    intEvt = ev;
    @(negedge clk);
    intEvt = 4'h0;
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic finishRun();
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(20 * 20000);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R13 reset state
    chk("R13 pixPerLine", 32'(pixPerLine), 32'd16);
    chk("R13 lineCount", 32'(lineCount), 32'd1);
    chk("R13 dispEnable", 32'(dispEnable), 32'd0);
    chk("R13 intOut", 32'(intOut), 32'd0);
    chk("R13 busErr", 32'(busErr), 32'd0);
    rd(12'h000, 32'h0, 1'b0, "R13 timing0 reset");
    rd(12'h200, 32'h0, 1'b0, "R13 palette reset");

    // R7 / R8 geometry, R1 readback
    wr(12'h000, 32'h0000_00A7);
    chk("R7 ppl 0xA7", 32'(pixPerLine), 32'd672);
    rd(12'h000, 32'h0000_00A7, 1'b0, "R1 timing0");
    wr(12'h000, 32'h0000_00FF);
    chk("R7 ppl max", 32'(pixPerLine), 32'd1024);
    wr(12'h000, 32'hFFFF_FF03);
    chk("R7 ppl min", 32'(pixPerLine), 32'd16);
    wr(12'h004, 32'h0000_0C1F);
    chk("R8 lines 0xC1F", 32'(lineCount), 32'd32);
    wr(12'h004, 32'h0000_03FF);
    chk("R8 lines max", 32'(lineCount), 32'd1024);
    rd(12'h004, 32'h0000_03FF, 1'b0, "R1 timing1");
    wr(12'h008, 32'h1111_2222);
    wr(12'h00C, 32'h3333_4444);
    wr(12'h010, 32'h8000_0000);
    wr(12'h014, 32'h0010_0000);
    rd(12'h008, 32'h1111_2222, 1'b0, "R1 timing2");
    rd(12'h00C, 32'h3333_4444, 1'b0, "R1 timing3");
    rd(12'h010, 32'h8000_0000, 1'b0, "R1 upper base");
    rd(12'h014, 32'h0010_0000, 1'b0, "R1 lower base");
    chk("R1 upperBase port", upperBase, 32'h8000_0000);
    chk("R1 lowerBase port", lowerBase, 32'h0010_0000);

    // R9 control decode
    wr(12'h018, 32'h0000_0001);
    chk("R9 enable only", 32'(dispEnable), 32'd0);
    wr(12'h018, 32'h0000_0800);
    chk("R9 power only", 32'(dispEnable), 32'd0);
    wr(12'h018, 32'h0000_0F0B);
    chk("R9 both", 32'(dispEnable), 32'd1);
    chk("R9 depth", 32'(colourDepth), 32'd5);
    chk("R9 order bits", {29'b0, bgrOrder, bigEndByte, bigEndPix}, 32'h7);
    rd(12'h018, 32'h0000_0F0B, 1'b0, "R2 control at index 6");
    wr(12'h01C, 32'hFFFF_FFF5);
    rd(12'h01C, 32'h0000_0005, 1'b0, "R2 mask at index 7");

    // R3 / R4 / R12 interrupts
    pulse(4'h6);
    rd(12'h020, 32'h6, 1'b0, "R3 raw");
    rd(12'h024, 32'h4, 1'b0, "R3 masked");
    chk("R12 irq high", 32'(intOut), 32'd1);
    wr(12'h028, 32'h0000_0004);
    rd(12'h020, 32'h2, 1'b0, "R4 clear one bit");
    chk("R12 irq low", 32'(intOut), 32'd0);
    wr(12'h028, 32'h0000_0002, 4'h2);
    rd(12'h020, 32'h2, 1'b0, "R4 set beats clear");
    wr(12'h028, 32'hFFFF_FFFF);
    rd(12'h020, 32'h0, 1'b0, "R4 clear all");

    // R5 palette
    wr(12'h200, 32'hDEAD_BEEF);
    wr(12'h3FC, 32'h1234_5678);
    wr(12'h27C, 32'hA5A5_A5A5);
    rd(12'h200, 32'hDEAD_BEEF, 1'b0, "R5 palette first");
    rd(12'h3FC, 32'h1234_5678, 1'b0, "R5 palette last");
    rd(12'h27C, 32'hA5A5_A5A5, 1'b0, "R5 palette mid");

    // R6 identification
    rd(12'hFE0, 32'h10, 1'b0, "R6 id0");
    rd(12'hFE4, 32'h11, 1'b0, "R6 id1");
    rd(12'hFE8, 32'h04, 1'b0, "R6 id2");
    rd(12'hFEC, 32'h00, 1'b0, "R6 id3");
    rd(12'hFFC, 32'hB1, 1'b0, "R6 id7");

    // R10 read-zero and read-only locations
    rd(12'h02C, 32'h0, 1'b0, "R10 index 11");
    rd(12'h030, 32'h0, 1'b0, "R10 index 12");
    wr(12'h020, 32'h0000_000F);
    wr(12'h024, 32'h0000_000F);
    rd(12'h020, 32'h0, 1'b0, "R10 raw is read-only");
    wr(12'hFE0, 32'h0000_0055);
    rd(12'hFE0, 32'h10, 1'b0, "R10 id is read-only");

    // R11 undefined offsets
    rd(12'h034, 32'h0, 1'b1, "R11 index 13");
    rd(12'h028, 32'h0, 1'b1, "R11 clear index read");
    rd(12'h400, 32'h0, 1'b1, "R11 hole above palette");
    rd(12'h202, 32'h0, 1'b1, "R11 misaligned");
    wr(12'hA00, 32'hFFFF_FFFF);
    wr(12'h201, 32'h0000_0000);
    rd(12'h200, 32'hDEAD_BEEF, 1'b0, "R11 stray writes ignored");

    // R13 reset clears state
    doReset();
    rd(12'h000, 32'h0, 1'b0, "R13 timing0 cleared");
    rd(12'h200, 32'h0, 1'b0, "R13 palette cleared");
    rd(12'h018, 32'h0, 1'b0, "R13 control cleared");
    chk("R13 upperBase cleared", upperBase, 32'h0);

    // R2 / R6 variant swap on both instances
    wr(12'h018, 32'h0000_0009);
    wr(12'h01C, 32'h0000_0801);
    chk("R2 base variant enable", 32'(dispEnable), 32'd0);
    chk("R2 alt variant enable", 32'(aEn), 32'd1);
    rdBoth(12'h018, 32'h9, 1'b0, 1'b1, 32'h9, 1'b0, "R2 index 6");
    rdBoth(12'h01C, 32'h1, 1'b0, 1'b1, 32'h801, 1'b0, "R2 index 7");
    rdBoth(12'hFE0, 32'h10, 1'b0, 1'b1, 32'h11, 1'b0, "R6 id0 variants");
    rdBoth(12'hFE8, 32'h04, 1'b0, 1'b1, 32'h24, 1'b0, "R6 id2 variants");

    repeat (2) @(negedge clk);
    finishRun();
  end
endmodule